// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block serialises characters onto a single transmit line. Each character goes out in an asynchronous frame. The frame opens with a low start bit. The data bits follow, then an optional parity bit, then one or two high stop bits. The frame format is chosen at run time through a small bank of configuration registers:

- character length: 5 to 9 bits
- bit order
- parity mode
- number of stop bits
- a baud divisor that sets how many clock cycles each bit lasts

Characters arrive on a valid/ready stream and land in a single holding register. While a frame is on the line, the next character can already wait in the holding register. It then follows with no idle gap.

The format and baud registers are locked while the block is enabled. Writes to them are dropped silently in that state. The control register stays writable at all times. It carries the block enable, the transmit enable and a soft-reset strobe. On the stream, `in_ready` is high only when both enables are set and the holding register is empty. A producer must hold `in_valid` and `in_data` steady until it sees `in_ready` at a clock edge. A byte counts as taken on the edge where both `in_valid` and `in_ready` are high.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is high and `in_ready` is low. Whenever no frame is in progress, `txd` is high.
- R2: Every bit of a frame, including the start bit, lasts exactly baud+1 clock cycles. Here baud is the value at address 2, which resets to 3. The start bit drives `txd` low.
- R3: The format register is at address 1. Its field [2:0] selects the character length: codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits, and codes 5 to 7 give 8 bits. Field [3] set sends the data most-significant bit first; clear sends it least-significant bit first. Only the low data bits up to the character length are sent.
- R4: Field [5:4] of the format register selects parity: 1 is even, 2 is odd, and 0 or 3 is none. With parity on, one parity bit follows the last data bit. It is computed over the sent data bits only. Even parity makes the count of ones over data and parity even. Odd parity makes that count odd.
- R5: The frame closes with one high stop bit, or two if format field [6] is set. After that the line stays high unless another character is waiting.
- R6: If a character is held when the last stop bit ends, and both enables are set, the next start bit begins on the very next cycle. There is no idle gap.
- R7: A write to the format register (address 1) or the baud register (address 2) while the enable bit is set is discarded. Such writes take effect while the enable bit is clear.
- R8: The control register is at address 0. Bit 0 is enable, bit 1 is soft reset and bit 2 is transmit enable. It accepts writes whether or not the block is enabled.
- R9: `in_ready` is high exactly when enable and transmit enable are both set and the holding register is empty. A byte taken on a handshake is transmitted unchanged.
- R10: Clearing transmit enable during a frame lets that frame finish correctly. The line then stays high, and a held character is not sent until transmit enable is set again.
- R11: Writing 1 to control bit 1 aborts any frame and clears the holding register. It returns every register to its reset value: enable and transmit enable clear, format code 3 with LSB first, no parity and one stop bit, and baud 3. On the next cycle `txd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| in_valid | input | 1 | Character offered on the stream |
| in_data | input | 9 | Character bits; the low bits up to the character length are used |
| in_ready | output | 1 | Holding register can take a character |
| txd | output | 1 | Serial transmit line, high when idle |

## Verification
The checker takes the following for granted about the inputs:
- A configuration write lasts one cycle, so a soft reset never lands in the same cycle as a format or baud write.
- A producer that raises `in_valid` keeps it and its data until a handshake.

The bench drives every configuration write through one task that pulses `cfg_we` for exactly one cycle. It pushes characters through a task that holds `in_valid` and the data until it has seen `in_ready` high across an edge. Because of this, the stream and lock properties only ever see legal traffic.

// File: rtl/uft_pkg.sv
package uft_pkg;

  // register addresses inside the configuration bank
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FMT  = 2'd1;
  localparam logic [1:0] ADDR_BAUD = 2'd2;

  // control register bit positions
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SRST_BIT  = 1;
  localparam int CTRL_TXEN_BIT  = 2;

  localparam int FMT_W = 7;

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF2 = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic       two_stop;
    logic [1:0] par;
    logic       msb_first;
    logic [2:0] len_code;
  } frame_fmt_t;

  localparam frame_fmt_t FMT_RESET = '{two_stop: 1'b0, par: 2'd0,
                                       msb_first: 1'b0, len_code: 3'd3};

  typedef enum logic [2:0] {
    TX_IDLE   = 3'd0,
    TX_START  = 3'd1,
    TX_DATA   = 3'd2,
    TX_PARITY = 3'd3,
    TX_STOP   = 3'd4
  } tx_state_e;

  // character length in bits for a length code
  function automatic logic [3:0] char_len(input logic [2:0] code);
    logic [3:0] r;
    if (code > 3'd4) r = 4'd8;
    else             r = {1'b0, code} + 4'd5;
    return r;
  endfunction

endpackage

// File: rtl/uft_cfg_bank.sv
module uft_cfg_bank
  import uft_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CFG_W    = 16,
  parameter int BAUD_W   = 16,
  parameter int BAUD_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output logic              enable,
  output logic              txen,
  output logic              srst,
  output frame_fmt_t        fmt,
  output logic [BAUD_W-1:0] baud
);

  localparam logic [BAUD_W-1:0] BAUD_DEF = BAUD_W'(BAUD_RST);

  logic hit_ctrl, hit_fmt, hit_baud;

  always_comb begin
    hit_ctrl = we && (addr == ADDR_W'(ADDR_CTRL));
    hit_fmt  = we && (addr == ADDR_W'(ADDR_FMT));
    hit_baud = we && (addr == ADDR_W'(ADDR_BAUD));
    srst     = hit_ctrl && wdata[CTRL_SRST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      txen   <= 1'b0;
      fmt    <= FMT_RESET;
      baud   <= BAUD_DEF;
    end else if (srst) begin
      enable <= 1'b0;
      txen   <= 1'b0;
      fmt    <= FMT_RESET;
      baud   <= BAUD_DEF;
    end else begin
      if (hit_ctrl) begin
        enable <= wdata[CTRL_EN_BIT];
        txen   <= wdata[CTRL_TXEN_BIT];
      end
      if (hit_fmt && !enable) begin
        fmt <= frame_fmt_t'(wdata[FMT_W-1:0]);
      end
      if (hit_baud && !enable) begin
        baud <= wdata[BAUD_W-1:0];
      end
    end
  end

endmodule

// File: rtl/uft_baud_gen.sv
module uft_baud_gen #(
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              run,
  input  logic [BAUD_W-1:0] reload_val,
  output logic              tick
);

  logic [BAUD_W-1:0] cnt_q;
  logic [BAUD_W-1:0] per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (clr || load) begin
      cnt_q <= reload_val;
      per_q <= reload_val;
    end else if (cnt_q == '0) begin
      cnt_q <= per_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/uft_frame_seq.sv
module uft_frame_seq
  import uft_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              go,
  input  frame_fmt_t        fmt,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              tick,
  output logic              take,
  output logic              busy,
  output tx_state_e         state,
  output logic              txd
);

  localparam int IDX_W = $clog2(DATA_W + 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  len_q;
  logic              msb_q;
  logic              par_en_q;
  logic              par_bit_q;
  logic              two_q;
  logic              stop_q;
  logic              last_stop;
  logic              data_bit;
  logic [IDX_W-1:0]  sel;

  function automatic logic par_of(input logic [DATA_W-1:0] d,
                                  input logic [IDX_W-1:0] len,
                                  input logic [1:0] mode);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (IDX_W'(i) < len) acc = acc ^ d[i];
    end
    return (mode == 2'(PAR_ODD)) ? ~acc : acc;
  endfunction

  always_comb begin
    last_stop = (stop_q == two_q);
    take = go && hold_full &&
           ((state_q == TX_IDLE) || ((state_q == TX_STOP) && tick && last_stop));
    sel = msb_q ? (len_q - IDX_W'(1) - idx_q) : idx_q;
    data_bit = data_q[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      data_q    <= '0;
      idx_q     <= '0;
      len_q     <= IDX_W'(8);
      msb_q     <= 1'b0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      two_q     <= 1'b0;
      stop_q    <= 1'b0;
    end else if (abort) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      stop_q  <= 1'b0;
    end else if (take) begin
      state_q   <= TX_START;
      data_q    <= hold_data;
      idx_q     <= '0;
      stop_q    <= 1'b0;
      len_q     <= IDX_W'(char_len(fmt.len_code));
      msb_q     <= fmt.msb_first;
      par_en_q  <= (fmt.par == 2'(PAR_EVEN)) || (fmt.par == 2'(PAR_ODD));
      par_bit_q <= par_of(hold_data, IDX_W'(char_len(fmt.len_code)), fmt.par);
      two_q     <= fmt.two_stop;
    end else if (tick) begin
      unique case (state_q)
        TX_START: begin
          state_q <= TX_DATA;
          idx_q   <= '0;
        end
        TX_DATA: begin
          if (idx_q == len_q - IDX_W'(1)) begin
            state_q <= par_en_q ? TX_PARITY : TX_STOP;
            stop_q  <= 1'b0;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        TX_PARITY: begin
          state_q <= TX_STOP;
          stop_q  <= 1'b0;
        end
        TX_STOP: begin
          if (last_stop) state_q <= TX_IDLE;
          else           stop_q  <= 1'b1;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      TX_START:  txd = 1'b0;
      TX_DATA:   txd = data_bit;
      TX_PARITY: txd = par_bit_q;
      default:   txd = 1'b1;
    endcase
  end

  assign busy  = (state_q != TX_IDLE);
  assign state = state_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CFG_W    = 16,
  parameter int BAUD_W   = 16,
  parameter int DATA_W   = 9,
  parameter int BAUD_RST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);

  logic              enable;
  logic              txen;
  logic              srst;
  frame_fmt_t        fmt;
  logic [BAUD_W-1:0] baud;
  logic              tick;
  logic              take;
  logic              busy;
  tx_state_e         state;
  logic              go;
  logic              hold_full_q;
  logic [DATA_W-1:0] hold_q;

  uft_cfg_bank #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .BAUD_W(BAUD_W), .BAUD_RST(BAUD_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .enable(enable), .txen(txen), .srst(srst), .fmt(fmt), .baud(baud)
  );

  uft_baud_gen #(.BAUD_W(BAUD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(srst), .load(take), .run(busy),
    .reload_val(baud), .tick(tick)
  );

  uft_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort(srst), .go(go), .fmt(fmt),
    .hold_full(hold_full_q), .hold_data(hold_q), .tick(tick),
    .take(take), .busy(busy), .state(state), .txd(txd)
  );

  assign go       = enable && txen;
  assign in_ready = go && !hold_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (srst) begin
      hold_full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      hold_full_q <= 1'b1;
      hold_q      <= in_data;
    end else if (take) begin
      hold_full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/uft_checker.sv
module uft_checker
  import uft_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CFG_W  = 16,
  parameter int BAUD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic              in_valid,
  input logic              in_ready,
  input logic              txd,
  input logic              enable,
  input logic              txen,
  input frame_fmt_t        fmt,
  input logic [BAUD_W-1:0] baud,
  input logic              tick,
  input logic              busy,
  input tx_state_e         state
);

  logic srst_wr;
  assign srst_wr = cfg_we && (cfg_addr == ADDR_W'(ADDR_CTRL)) && cfg_wdata[CTRL_SRST_BIT];

  assert_ready_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (enable && txen));

  assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_fmt_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(ADDR_FMT) && enable) |=> $stable(fmt));

  assert_baud_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADDR_W'(ADDR_BAUD) && enable) |=> $stable(baud));

  assert_srst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_wr |=> (txd && !busy));

  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !srst_wr) |=> $stable(state));

endmodule

bind uart_frame_tx uft_checker #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .BAUD_W(BAUD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready), .txd(txd),
  .enable(enable), .txen(txen), .fmt(fmt), .baud(baud), .tick(tick),
  .busy(busy), .state(state)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       in_ready;
  logic       txd;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [8:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int build(input logic [8:0] d, input int len, input int msb,
                               input int par, input int two, output logic [15:0] b);
    int n;
    logic p;
    b = '1; n = 0; p = 1'b0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < len; i++) begin
      b[n] = (msb != 0) ? d[len-1-i] : d[i];
      n++;
    end
    for (int i = 0; i < len; i++) p = p ^ d[i];
    if (par == 1) begin b[n] = p;  n++; end
    if (par == 2) begin b[n] = ~p; n++; end
    n++;
    if (two != 0) n++;
    return n;
  endfunction

  // watches one frame; returns at the cycle right after its last stop bit
  task automatic watch(input logic [8:0] d, input int lenc, input int msb,
                       input int par, input int two, input int per,
                       input bit already, input string req, output longint st);
    logic [15:0] b;
    int n, mism, guard;
    n = build(d, lenc + 5, msb, par, two, b);
    if (!already) begin
      guard = 0;
      @(negedge clk);
      while (txd !== 1'b0 && guard < 3000) begin @(negedge clk); guard++; end
      if (guard >= 3000) chk(0, {req, " no start bit"}, 1, 0);
    end
    st = cyc;
    mism = 0;
    for (int off = 0; off < n * per; off++) begin
      if (txd !== b[off / per]) mism++;
      @(negedge clk);
    end
    chk(mism == 0, req, mism, 0);
  endtask

  task automatic setup(input int lenc, input int msb, input int par,
                       input int two, input int baud);
    cfg_write(2'd0, 16'h0000);
    cfg_write(2'd1, 16'(lenc | (msb << 3) | (par << 4) | (two << 6)));
    cfg_write(2'd2, 16'(baud));
    cfg_write(2'd0, 16'h0005);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint s0, s1;
    logic [8:0] d;
    int hi;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(in_ready === 1'b0, "R1 in_ready after reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd === 1'b1 && in_ready === 1'b0, "R1 idle while disabled", txd, 1);

    // R2 R3 R4 R5 sweep over every format, baud 2
    for (int lc = 0; lc < 5; lc++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 3; p++)
          for (int t = 0; t < 2; t++)
            for (int v = 0; v < 2; v++) begin
              setup(lc, m, p, t, 2);
              d = 9'((lc * 37 + m * 11 + p * 5 + t * 3 + 90) ^ (v != 0 ? 9'h1FF : 9'h000));
              fork
                push(d);
                watch(d, lc, m, p, t, 3, 1'b0, "R3 R4 R5 format sweep", s0);
              join
              chk(txd === 1'b1, "R5 idle after stop", txd, 1);
            end

    // R2 other bit periods
    setup(3, 0, 0, 0, 0);
    fork push(9'h0C3); watch(9'h0C3, 3, 0, 0, 0, 1, 1'b0, "R2 baud 0", s0); join
    setup(3, 0, 1, 1, 5);
    fork push(9'h13C); watch(9'h13C, 3, 0, 1, 1, 6, 1'b0, "R2 baud 5", s0); join

    // R6 back-to-back, R9 back-pressure
    setup(3, 0, 1, 0, 2);
    fork
      begin
        push(9'h0A5);
        push(9'h05A);
        chk(in_ready === 1'b0, "R9 ready low while holding", in_ready, 0);
      end
      watch(9'h0A5, 3, 0, 1, 0, 3, 1'b0, "R6 first frame", s0);
    join
    chk(txd === 1'b0, "R6 no idle gap", txd, 0);
    watch(9'h05A, 3, 0, 1, 0, 3, 1'b1, "R6 second frame", s1);
    chk(s1 - s0 == 11 * 3, "R6 start spacing", s1 - s0, 33);

    // R7 lock while enabled
    setup(3, 0, 0, 0, 2);
    cfg_write(2'd1, 16'h006C);
    cfg_write(2'd2, 16'd7);
    fork push(9'h0A5); watch(9'h0A5, 3, 0, 0, 0, 3, 1'b0, "R7 writes dropped", s0); join
    setup(4, 1, 2, 1, 7);
    fork push(9'h1A5); watch(9'h1A5, 4, 1, 2, 1, 8, 1'b0, "R7 writes taken when disabled", s0); join

    // R8 control writable while enabled
    setup(3, 0, 0, 0, 2);
    cfg_write(2'd0, 16'h0001);
    chk(in_ready === 1'b0, "R8 txen cleared while enabled", in_ready, 0);
    cfg_write(2'd0, 16'h0005);
    chk(in_ready === 1'b1, "R8 txen set while enabled", in_ready, 1);

    // R10 clear transmit enable mid-frame
    fork
      begin
        push(9'h033);
        push(9'h0CC);
        cfg_write(2'd0, 16'h0001);
      end
      watch(9'h033, 3, 0, 0, 0, 3, 1'b0, "R10 frame finishes", s0);
    join
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      if (txd === 1'b1) hi++;
      @(negedge clk);
    end
    chk(hi == 40, "R10 line held idle", hi, 40);
    chk(in_ready === 1'b0, "R10 ready low", in_ready, 0);
    cfg_write(2'd0, 16'h0005);
    watch(9'h0CC, 3, 0, 0, 0, 3, 1'b0, "R10 held byte after re-enable", s0);

    // R11 soft reset mid-frame
    setup(2, 1, 1, 1, 2);
    fork
      push(9'h055);
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (5) @(negedge clk);
      end
    join
    push(9'h1FF);
    cfg_write(2'd0, 16'h0002);
    chk(txd === 1'b1, "R11 txd high after soft reset", txd, 1);
    chk(in_ready === 1'b0, "R11 enables cleared", in_ready, 0);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (txd === 1'b1) hi++;
      @(negedge clk);
    end
    chk(hi == 20, "R11 frame aborted", hi, 20);
    cfg_write(2'd0, 16'h0005);
    fork push(9'h096); watch(9'h096, 3, 0, 0, 0, 4, 1'b0, "R11 defaults restored", s0); join
    chk(txd === 1'b1, "R1 idle at end", txd, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule